// File: doc/BRIEF.md
# Shared-Count Input Debounce Filter for an Eight-Pin Port

This block cleans up the synchronized input levels of one eight-pin port before they reach the input register and the interrupt edge detector. All pins of the port share one 8-bit stable-time setting, in milliseconds, so the longest setting is 255 ms. Each pin still keeps its own stability counter, so every pin settles on its own schedule. A per-pin enable picks which pins go through the filter. Pins that are not enabled reach the output with no delay.

Time is counted in pulses of a one-millisecond tick input, which is made elsewhere. The stable time is a plain 8-bit register. The enable register takes a masked write: the upper half of the write word picks which bits change, and the lower half gives their new values. A filtered pin takes its new level only after the raw input has stayed at that level for the programmed number of consecutive ticks. If the input returns to the old level before then, the pin's count starts again from zero.

Top module: `port_debounce`

## Requirements
- R1: A write with `cnt_we` high stores `cnt_wdata` into the shared stable-time register, which appears on `cfg_count` one cycle later. With no write the register holds its value. After reset it is 0.
- R2: A write with `en_we` high updates enable bit i to `en_wdata[i]` only where select bit `en_wdata[8+i]` is 1. Bits whose select bit is 0 keep their value. `cfg_enable` shows the register, and it is 0 after reset.
- R3: A pin whose enable bit is 0 drives `pin_raw[i]` onto `pin_filt[i]` combinationally, in the same cycle.
- R4: When the stable time is 0, enabled pins also follow `pin_raw` combinationally.
- R5: For an enabled pin with stable time N > 0, `pin_filt[i]` takes a new raw level at the clock edge that samples the Nth consecutive `tick_ms` pulse during which the raw level differed from the filtered level.
- R6: If an enabled pin's raw level goes back to its filtered level before N ticks have been counted, its counter clears and the output does not change.
- R7: Clock cycles without `tick_ms` neither advance a pin's counter nor change its filtered level.
- R8: Synchronous reset loads each pin's filtered state from `pin_raw` and clears every per-pin counter.
- R9: One stable time serves all enabled pins, while each pin counts on its own, so pins that start changing at different ticks settle at different ticks.
- R10: The largest stable time, 255, holds the old level through 254 ticks and changes it on the 255th.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_ms | input | 1 | One-cycle pulse each millisecond |
| pin_raw | input | 8 | Synchronized raw pin levels |
| cnt_we | input | 1 | Write strobe for the stable-time register |
| cnt_wdata | input | 8 | Stable time in ms |
| en_we | input | 1 | Write strobe for the masked enable register |
| en_wdata | input | 16 | [15:8] bit select, [7:0] new enable values |
| cfg_count | output | 8 | Current stable-time register |
| cfg_enable | output | 8 | Current per-pin enable register |
| pin_filt | output | 8 | Filtered pin levels |

## Verification
A cycle-by-cycle table with a stable time of 2 applies clean level changes, changes interleaved with tick-free cycles, a bounce that returns to the old level after one tick, and changes on several pins that start at different ticks. Together these separate a correct tick count from counting clock cycles, from failing to restart after a bounce, and from sharing one counter across pins. Directed tests then check the following:
- Masked writes that leave unselected enable bits alone.
- Disabled pins and a stable time of 0 passing raw levels through within the same cycle.
- A stable time of 5 starting from reset values.
- The 255 limit, compared at the 254th and the 255th tick.

// File: rtl/dbnc_pkg.sv
package dbnc_pkg;

    // Width of the shared stable-time register (milliseconds).
    localparam int CNT_W = 8;
    // Pins served by one port.
    localparam int PINS = 8;

    typedef logic [CNT_W-1:0] cnt_t;

    // State of one pin's filter.
    typedef struct packed {
        logic filt;
        cnt_t ctr;
    } lane_t;

    // Next state of one pin's filter.
    function automatic lane_t lane_next(
        input lane_t cur,
        input logic  raw,
        input logic  tick,
        input cnt_t  limit,
        input logic  bypass
    );
        lane_t nxt;
        logic [CNT_W:0] reached;
        nxt     = cur;
        reached = {1'b0, cur.ctr} + {{CNT_W{1'b0}}, 1'b1};
        if (bypass) begin
            nxt.filt = raw;
            nxt.ctr  = '0;
        end else if (raw == cur.filt) begin
            nxt.ctr = '0;
        end else if (tick) begin
            if (reached >= {1'b0, limit}) begin
                nxt.filt = raw;
                nxt.ctr  = '0;
            end else begin
                nxt.ctr = reached[CNT_W-1:0];
            end
        end
        return nxt;
    endfunction

endpackage

// File: rtl/dbnc_cfg.sv
module dbnc_cfg
    import dbnc_pkg::*;
#(
    parameter int NUM_PINS = PINS
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cnt_we,
    input  cnt_t                  cnt_wdata,
    input  logic                  en_we,
    input  logic [2*NUM_PINS-1:0] en_wdata,
    output cnt_t                  count_q,
    output logic [NUM_PINS-1:0]   enable_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (cnt_we) begin
            count_q <= cnt_wdata;
        end
    end

    // Masked write: upper half selects, lower half supplies the value.
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_en
        always_ff @(posedge clk) begin
            if (rst) begin
                enable_q[i] <= 1'b0;
            end else if (en_we && en_wdata[NUM_PINS+i]) begin
                enable_q[i] <= en_wdata[i];
            end
        end
    end

    a_r1_count_hold: assert property (@(posedge clk) disable iff (rst)
        !cnt_we |=> count_q == $past(count_q));

    a_r2_unselected_hold: assert property (@(posedge clk) disable iff (rst)
        en_we |=> ((enable_q ^ $past(enable_q)) & ~$past(en_wdata[2*NUM_PINS-1:NUM_PINS])) == '0);

    a_r2_no_write_hold: assert property (@(posedge clk) disable iff (rst)
        !en_we |=> enable_q == $past(enable_q));

endmodule

// File: rtl/dbnc_lane.sv
module dbnc_lane
    import dbnc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic raw,
    input  logic enable,
    input  cnt_t limit,
    output logic filt_out
);

    lane_t st_q;
    logic  bypass;

    assign bypass = !enable || (limit == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.filt <= raw;
            st_q.ctr  <= '0;
        end else begin
            st_q <= lane_next(st_q, raw, tick, limit, bypass);
        end
    end

    assign filt_out = bypass ? raw : st_q.filt;

    // R3 / R4: while bypassed the stored state tracks the raw level.
    a_r3_bypass_track: assert property (@(posedge clk) disable iff (rst)
        bypass |=> st_q.filt == $past(raw));

    a_r7_no_tick_hold: assert property (@(posedge clk) disable iff (rst)
        (!bypass && !tick) |=> st_q.filt == $past(st_q.filt));

    a_r6_match_clear: assert property (@(posedge clk) disable iff (rst)
        (!bypass && raw == st_q.filt) |=> st_q.ctr == '0);

    a_r5_ctr_step: assert property (@(posedge clk) disable iff (rst)
        (!bypass && tick && raw != st_q.filt) |=>
            (st_q.ctr == '0 || {1'b0, st_q.ctr} == {1'b0, $past(st_q.ctr)} + 1'b1));

endmodule

// File: rtl/port_debounce.sv
module port_debounce
    import dbnc_pkg::*;
#(
    parameter int NUM_PINS = PINS,
    localparam int SEL_W   = 2 * NUM_PINS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick_ms,
    input  logic [NUM_PINS-1:0] pin_raw,
    input  logic                cnt_we,
    input  logic [CNT_W-1:0]    cnt_wdata,
    input  logic                en_we,
    input  logic [SEL_W-1:0]    en_wdata,
    output logic [CNT_W-1:0]    cfg_count,
    output logic [NUM_PINS-1:0] cfg_enable,
    output logic [NUM_PINS-1:0] pin_filt
);

    dbnc_cfg #(.NUM_PINS(NUM_PINS)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cnt_we    (cnt_we),
        .cnt_wdata (cnt_wdata),
        .en_we     (en_we),
        .en_wdata  (en_wdata),
        .count_q   (cfg_count),
        .enable_q  (cfg_enable)
    );

    // R9: one shared limit, one counter per pin.
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_lane
        dbnc_lane u_lane (
            .clk      (clk),
            .rst      (rst),
            .tick     (tick_ms),
            .raw      (pin_raw[i]),
            .enable   (cfg_enable[i]),
            .limit    (cfg_count),
            .filt_out (pin_filt[i])
        );
    end

    a_r3_disabled_pass: assert property (@(posedge clk) disable iff (rst)
        ((pin_filt ^ pin_raw) & ~cfg_enable) == '0);

endmodule

// File: tb/sim_port_debounce.sv
module sim_port_debounce;

    localparam int PER = 10;

    typedef struct packed {
        logic [7:0] raw;
        logic       tick;
        logic [7:0] exp;
    } vec_t;

    // Stable time 2, all pins enabled, filtered state starts at 00.
    // Covers R5 (count to 2), R6 (bounce on pin 1), R7 (tick-free cycles), R9 (pins 0/7 offset).
    localparam vec_t TABLE [14] = '{
        '{8'h01, 1'b0, 8'h00},
        '{8'h01, 1'b1, 8'h00},
        '{8'h01, 1'b0, 8'h00},
        '{8'h01, 1'b1, 8'h01},
        '{8'h03, 1'b1, 8'h01},
        '{8'h01, 1'b0, 8'h01},
        '{8'h03, 1'b1, 8'h01},
        '{8'h03, 1'b1, 8'h03},
        '{8'h02, 1'b1, 8'h03},
        '{8'h82, 1'b1, 8'h02},
        '{8'h82, 1'b1, 8'h82},
        '{8'h00, 1'b0, 8'h82},
        '{8'h00, 1'b1, 8'h82},
        '{8'h00, 1'b1, 8'h00}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_ms = 1'b0;
    logic [7:0]  pin_raw = 8'hA5;
    logic        cnt_we = 1'b0;
    logic [7:0]  cnt_wdata = '0;
    logic        en_we = 1'b0;
    logic [15:0] en_wdata = '0;
    logic [7:0]  cfg_count;
    logic [7:0]  cfg_enable;
    logic [7:0]  pin_filt;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #(PER/2) clk = ~clk;

    port_debounce u0 (
        .clk        (clk),
        .rst        (rst),
        .tick_ms    (tick_ms),
        .pin_raw    (pin_raw),
        .cnt_we     (cnt_we),
        .cnt_wdata  (cnt_wdata),
        .en_we      (en_we),
        .en_wdata   (en_wdata),
        .cfg_count  (cfg_count),
        .cfg_enable (cfg_enable),
        .pin_filt   (pin_filt)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr_count(input logic [7:0] v);
        @(negedge clk);
        cnt_we = 1'b1; cnt_wdata = v;
        @(negedge clk);
        cnt_we = 1'b0;
    endtask

    task automatic wr_enable(input logic [15:0] v);
        @(negedge clk);
        en_we = 1'b1; en_wdata = v;
        @(negedge clk);
        en_we = 1'b0;
    endtask

    // Drive at negedge, let one edge pass, sample a quarter period later.
    task automatic step(input logic [7:0] raw, input logic tk);
        @(negedge clk);
        pin_raw = raw; tick_ms = tk;
        @(posedge clk);
        #(PER/4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #(PER/4);
        check("R1 reset count", cfg_count, 8'h00);
        check("R2 reset enable", cfg_enable, 8'h00);
        check("R8 reset filt", pin_filt, 8'hA5);

        wr_count(8'd5);
        check("R1 count write", cfg_count, 8'd5);
        wr_enable(16'hFFFF);
        check("R2 enable all", cfg_enable, 8'hFF);
        check("R8 state from reset raw", pin_filt, 8'hA5);

        // R5 with stable time 5
        for (int k = 1; k <= 5; k++) begin
            step(8'h5A, 1'b1);
            if (k == 4) check("R5 n=5 before 5th tick", pin_filt, 8'hA5);
            if (k == 5) check("R5 n=5 at 5th tick", pin_filt, 8'h5A);
        end
        @(negedge clk); tick_ms = 1'b0;

        wr_enable(16'h0F00);
        check("R2 masked clear low nibble", cfg_enable, 8'hF0);
        wr_enable(16'h00FF);
        check("R2 unselected bits held", cfg_enable, 8'hF0);

        // R3: disabled low nibble passes through before any clock edge
        @(negedge clk);
        pin_raw = 8'h4B;
        #1;
        check("R3 disabled pins pass raw", pin_filt, 8'h5B);

        // R4: stable time 0 makes enabled pins follow at once
        wr_count(8'd0);
        check("R4 count zero follow", pin_filt, 8'h4B);
        @(negedge clk);
        pin_raw = 8'hA4;
        #1;
        check("R4 count zero same cycle", pin_filt, 8'hA4);

        // Prepare table: raw 00 while bypassed, then stable time 2
        @(negedge clk);
        pin_raw = 8'h00;
        wr_enable(16'hFFFF);
        wr_count(8'd2);
        for (int i = 0; i < 14; i++) begin
            step(TABLE[i].raw, TABLE[i].tick);
            check($sformatf("R5/R6/R7/R9 table row %0d", i), pin_filt, TABLE[i].exp);
        end
        @(negedge clk); tick_ms = 1'b0;

        // R10: stable time 255
        wr_count(8'd255);
        for (int k = 1; k <= 255; k++) begin
            step(8'h01, 1'b1);
            if (k == 254) check("R10 held after 254 ticks", pin_filt, 8'h00);
            if (k == 255) check("R10 change at 255th tick", pin_filt, 8'h01);
        end
        @(negedge clk); tick_ms = 1'b0;

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(PER * 20000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule